// File: doc/BRIEF.md
# Reconfiguration Command Sequencer

This block reboots the device into one of four configuration images held in external flash. When asked to restart, it writes the full restart command sequence, one 32-bit word per clock, into the device's internal configuration access port. The sequence first loads the warm-boot start register with the chosen image address and then issues the restart command. The port takes its data with the bits of each byte mirrored, so the block reverses the bit order inside every byte before the word leaves it.

A 2-bit select input picks one of four flash slots, and each slot's start address is a parameter. Slot 0 holds the fallback image at flash address 0. A remote host may instead write an arbitrary start address through a register write port. The next start request uses that address once, and requests after it use the slot table again. While the block is busy it ignores further start requests. When it finishes, it pulses a one-cycle done flag.

Top module: `cfg_restart_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, busy and done are low, both port strobes are high (deasserted) and the port data is zero.
- R2: A start request sampled in idle makes the port carry eight words on the next eight cycles, in this order: 0xFFFFFFFF, 0xAA995566, 0x20000000, 0x30020001, the 32-bit start address, 0x30008001, 0x0000000F, 0x20000000.
- R3: Each word is driven with the bits mirrored inside each byte: bit 8*b+i of the port equals bit 8*b+7-i of the command word, for bytes b=0..3 and i=0..7.
- R4: Without a pending host address, select values 0, 1, 2 and 3 give start addresses 0x0000000, 0x0800000, 0x1000000 and 0x1800000 (the defaults). Select 0 always maps to address 0.
- R5: A host register write stores a pending start address. The next start request uses it in place of the slot address and consumes it, so the request after that uses the slot table again.
- R6: Chip-select and write strobes are active low. They are low for exactly the eight word cycles and high in every other cycle.
- R7: Busy is high for exactly the eight word cycles. Done is high for exactly one cycle, the cycle right after the last word, and busy is then low.
- R8: A start request that arrives while busy has no effect. The running sequence is unchanged and no new sequence follows it.
- R9: When a start request and a host write fall in the same idle cycle, the start uses the address source that was valid before that cycle. The newly written address stays pending for the following start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 2 | Flash slot select |
| start_i | input | 1 | Restart request strobe |
| addr_wr_i | input | 1 | Host write strobe for the pending start address |
| addr_wdata_i | input | 32 | Host start address value |
| cap_data_o | output | 32 | Configuration port data, bit-mirrored per byte |
| cap_csn_o | output | 1 | Configuration port chip select, active low |
| cap_wrn_o | output | 1 | Configuration port write strobe, active low |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse after the last word |

## Verification
Two functions can meet in one cycle. A start request can coincide with a host address write, and a start request can arrive while a sequence is already running. The bench drives a start and a host write on the same idle edge, then checks two things: the address word of that run comes from the previous source, and the newly written address appears in the run that follows. Start pulses injected mid-sequence with a different select must leave every word of the running sequence intact, and no new sequence may begin after done.

// File: rtl/cfg_restart_pkg.sv
package cfg_restart_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'd0,
        ST_DUMMY   = 4'd1,
        ST_SYNC    = 4'd2,
        ST_NOP_A   = 4'd3,
        ST_HDR_WB  = 4'd4,
        ST_ADDR    = 4'd5,
        ST_HDR_CMD = 4'd6,
        ST_RESTART = 4'd7,
        ST_NOP_B   = 4'd8
    } seq_state_e;

    localparam int unsigned WORD_W = 32;

    localparam logic [WORD_W-1:0] W_DUMMY   = 32'hFFFF_FFFF;
    localparam logic [WORD_W-1:0] W_SYNC    = 32'hAA99_5566;
    localparam logic [WORD_W-1:0] W_NOP     = 32'h2000_0000;
    localparam logic [WORD_W-1:0] W_HDR_WB  = 32'h3002_0001;
    localparam logic [WORD_W-1:0] W_HDR_CMD = 32'h3000_8001;
    localparam logic [WORD_W-1:0] W_RESTART = 32'h0000_000F;

    typedef struct packed {
        seq_state_e        st;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] host;
        logic              host_vld;
        logic [WORD_W-1:0] word;
        logic              strb_n;
        logic              done;
    } seq_regs_t;

endpackage

// File: rtl/cfg_slot_map.sv
module cfg_slot_map #(
    parameter int unsigned        SEL_W  = 2,
    parameter int unsigned        ADDR_W = 32,
    parameter logic [ADDR_W-1:0]  SLOT0  = 32'h0000_0000,
    parameter logic [ADDR_W-1:0]  SLOT1  = 32'h0080_0000,
    parameter logic [ADDR_W-1:0]  SLOT2  = 32'h0100_0000,
    parameter logic [ADDR_W-1:0]  SLOT3  = 32'h0180_0000
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        unique case (sel)
            2'd0:    addr = SLOT0;
            2'd1:    addr = SLOT1;
            2'd2:    addr = SLOT2;
            default: addr = SLOT3;
        endcase
    end
endmodule

// File: rtl/cfg_byte_mirror.sv
module cfg_byte_mirror #(
    parameter int unsigned BYTES = 4,
    localparam int unsigned W    = BYTES * 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        for (genvar i = 0; i < 8; i++) begin : g_bit
            assign dout[8*b + i] = din[8*b + 7 - i];
        end
    end
endmodule

// File: rtl/cfg_restart_seq.sv
module cfg_restart_seq
    import cfg_restart_pkg::*;
#(
    parameter logic [31:0] SLOT0 = 32'h0000_0000,
    parameter logic [31:0] SLOT1 = 32'h0080_0000,
    parameter logic [31:0] SLOT2 = 32'h0100_0000,
    parameter logic [31:0] SLOT3 = 32'h0180_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  sel_i,
    input  logic        start_i,
    input  logic        addr_wr_i,
    input  logic [31:0] addr_wdata_i,
    output logic [31:0] cap_data_o,
    output logic        cap_csn_o,
    output logic        cap_wrn_o,
    output logic        busy_o,
    output logic        done_o
);
    seq_regs_t    q, d;
    logic [31:0]  slot_addr;

    cfg_slot_map #(
        .SEL_W (2), .ADDR_W(32),
        .SLOT0 (SLOT0), .SLOT1(SLOT1), .SLOT2(SLOT2), .SLOT3(SLOT3)
    ) u_map (
        .sel  (sel_i),
        .addr (slot_addr)
    );

    cfg_byte_mirror #(.BYTES(4)) u_mirror (
        .din  (q.word),
        .dout (cap_data_o)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st       = ST_DUMMY;
                    d.addr     = q.host_vld ? q.host : slot_addr;
                    d.host_vld = 1'b0;
                end
            end
            ST_DUMMY:   d.st = ST_SYNC;
            ST_SYNC:    d.st = ST_NOP_A;
            ST_NOP_A:   d.st = ST_HDR_WB;
            ST_HDR_WB:  d.st = ST_ADDR;
            ST_ADDR:    d.st = ST_HDR_CMD;
            ST_HDR_CMD: d.st = ST_RESTART;
            ST_RESTART: d.st = ST_NOP_B;
            ST_NOP_B: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
            end
            default:    d.st = ST_IDLE;
        endcase

        // host write applies after start so a same-cycle write stays pending
        if (addr_wr_i) begin
            d.host     = addr_wdata_i;
            d.host_vld = 1'b1;
        end

        unique case (d.st)
            ST_DUMMY:   d.word = W_DUMMY;
            ST_SYNC:    d.word = W_SYNC;
            ST_NOP_A:   d.word = W_NOP;
            ST_HDR_WB:  d.word = W_HDR_WB;
            ST_ADDR:    d.word = d.addr;
            ST_HDR_CMD: d.word = W_HDR_CMD;
            ST_RESTART: d.word = W_RESTART;
            ST_NOP_B:   d.word = W_NOP;
            default:    d.word = '0;
        endcase
        d.strb_n = (d.st == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st       <= ST_IDLE;
            q.addr     <= '0;
            q.host     <= '0;
            q.host_vld <= 1'b0;
            q.word     <= '0;
            q.strb_n   <= 1'b1;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cap_csn_o = q.strb_n;
    assign cap_wrn_o = q.strb_n;
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
endmodule

// File: rtl/cfg_restart_chk.sv
module cfg_restart_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cap_data_o,
    input logic        cap_csn_o,
    input logic        busy_o,
    input logic        done_o
);
    logic [3:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)         run_q <= '0;
        else if (busy_o) run_q <= (run_q == 4'd15) ? run_q : run_q + 4'd1;
        else             run_q <= '0;
    end

    a_r6_strobe_tracks_busy: assert property (@(posedge clk) disable iff (rst)
        busy_o == !cap_csn_o);

    a_r2_first_word_dummy: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> cap_data_o == 32'hFFFF_FFFF);

    a_r3_sync_mirrored: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |=> cap_data_o == 32'h5599_AA66);

    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(busy_o) && !busy_o));

    a_r7_busy_len: assert property (@(posedge clk) disable iff (rst)
        run_q <= 4'd8);

    a_r1_idle_data_zero: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> cap_data_o == 32'h0);
endmodule

bind cfg_restart_seq cfg_restart_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cap_data_o (cap_data_o),
    .cap_csn_o  (cap_csn_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/tb_cfg_restart_seq.sv
module tb_cfg_restart_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel_i = '0;
    logic        start_i = 1'b0;
    logic        addr_wr_i = 1'b0;
    logic [31:0] addr_wdata_i = '0;
    logic [31:0] cap_data_o;
    logic        cap_csn_o, cap_wrn_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    logic        host_pend = 1'b0;
    logic [31:0] host_val  = '0;

    always #4 clk = ~clk;

    cfg_restart_seq dut (.*);

    function automatic logic [31:0] mirror(input logic [31:0] w);
        logic [31:0] r;
        for (int k = 0; k < 32; k++) r[(k/8)*8 + 7 - (k%8)] = w[k];
        return r;
    endfunction

    function automatic logic [31:0] slot_of(input logic [1:0] s);
        return {7'd0, s, 23'd0};
    endfunction

    function automatic logic [31:0] word_of(input int k, input logic [31:0] a);
        case (k)
            0: return 32'hFFFF_FFFF;
            1: return 32'hAA99_5566;
            2: return 32'h2000_0000;
            3: return 32'h3002_0001;
            4: return a;
            5: return 32'h3000_8001;
            6: return 32'h0000_000F;
            default: return 32'h2000_0000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] v);
        @(negedge clk);
        addr_wr_i = 1'b1; addr_wdata_i = v;
        @(negedge clk);
        addr_wr_i = 1'b0;
        host_pend = 1'b1; host_val = v;
    endtask

    // start (optionally with same-cycle write), check all words, done, and quiet aftermath
    task automatic run_seq(input logic [1:0] s, input bit intrude, input bit wr, input logic [31:0] wv);
        logic [31:0] ea;
        ea = host_pend ? host_val : slot_of(s);
        host_pend = 1'b0;
        @(negedge clk);
        sel_i = s; start_i = 1'b1;
        addr_wr_i = wr; addr_wdata_i = wv;
        @(negedge clk);
        start_i = 1'b0; addr_wr_i = 1'b0;
        if (wr) begin host_pend = 1'b1; host_val = wv; end
        for (int k = 0; k < 8; k++) begin
            if (k == 4)
                chk(cap_data_o == mirror(ea), (wr ? "R9 addr word" : (intrude ? "R8 addr word" : "R4/R5 addr word")),
                    cap_data_o, mirror(ea));
            else
                chk(cap_data_o == mirror(word_of(k, ea)), "R2/R3 word", cap_data_o, mirror(word_of(k, ea)));
            chk(busy_o && !cap_csn_o && !cap_wrn_o && !done_o, "R6/R7 strobes busy",
                {28'd0, busy_o, cap_csn_o, cap_wrn_o, done_o}, 32'h8);
            if (intrude && (k == 3 || k == 6)) begin
                sel_i = ~s; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(done_o && !busy_o && cap_csn_o && cap_wrn_o, "R7 done pulse",
            {28'd0, busy_o, cap_csn_o, cap_wrn_o, done_o}, 32'h7);
        @(negedge clk);
        chk(!done_o && !busy_o && cap_csn_o, (intrude ? "R8 no relaunch" : "R7 done single"),
            {28'd0, busy_o, cap_csn_o, cap_wrn_o, done_o}, 32'h6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && cap_csn_o && cap_wrn_o && cap_data_o == 0, "R1 in reset",
            cap_data_o, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && !done_o && cap_csn_o && cap_wrn_o && cap_data_o == 0, "R1 after reset",
            cap_data_o, 32'h0);

        // R4 every slot, R2/R3 full sequences
        for (int s = 0; s < 4; s++) run_seq(2'(s), 1'b0, 1'b0, '0);
        // R8 start while busy
        run_seq(2'd1, 1'b1, 1'b0, '0);
        // R5 host address used once, then slot again
        host_write(32'h1234_5678);
        run_seq(2'd2, 1'b0, 1'b0, '0);
        run_seq(2'd2, 1'b0, 1'b0, '0);
        // R9 same-cycle start and write, with and without prior pending value
        host_write(32'h00C0_FFEE);
        run_seq(2'd3, 1'b0, 1'b1, 32'h0A5A_5A5A);
        run_seq(2'd0, 1'b0, 1'b0, '0);
        run_seq(2'd0, 1'b0, 1'b1, 32'h8000_0001);
        run_seq(2'd1, 1'b0, 1'b0, '0);

        // constrained random mix
        for (int n = 0; n < 30; n++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:2] == 2'd0) host_write($urandom);
            run_seq(r[1:0], r[4], (r[7:5] == 3'd0), $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule